// File: doc/BRIEF.md
# Multi-Cycle Processor Controller

This block is the sequencing core of a small 32-bit load/store processor that runs each instruction over several clock cycles. A finite-state machine steps through fetch, decode, execute, memory and write-back phases. In each step it drives the datapath selects and enables, and these depend on both the current step and the opcode being executed. Every phase reuses one adder/logic unit: it advances the program counter, precomputes the branch target, forms load and store addresses, and performs the arithmetic.

The datapath around the controller holds the program counter, the instruction register, the two operand latches, the ALU result latch, the memory data latch and a 32-entry register file. The block has one shared memory port for both instructions and data. The memory is expected to return read data in the same cycle as the address. Writes are expected to take effect at the next rising edge. The current step code and program counter are brought out so that an integrator can follow instruction progress.

Top module: `mc_cpu`

## Requirements
- R1: After reset, PC is 0, the step code is 0 (fetch) and mem_wr is low. mem_rd and mem_wr are never both high in the same cycle.
- R2: In step 0 the block reads memory at PC and latches the word as the current instruction. It advances PC by 4 and then moves to step 1.
- R3: In step 1 (decode) PC does not change. The next step is one of the following: 2 (address), 6 (register execute), 8 (branch), 9 (jump) or 0. Step 3 is the load memory read, step 4 the load write-back, step 5 the store write and step 7 the register write-back.
- R4: Opcode 0 with function code 0x20, 0x22, 0x24, 0x25 or 0x2A performs add, subtract, AND, OR or signed set-less-than of rs and rt. The result goes to rd, and the instruction takes 4 cycles.
- R5: Opcode 0x23 loads the word at rs plus the sign-extended 16-bit offset into rt, and takes 5 cycles.
- R6: Opcode 0x2B stores rt at rs plus the sign-extended offset and takes 4 cycles. mem_wr is high only in step 5, and only once per store.
- R7: Opcode 0x04 takes 3 cycles. When rs equals rt, PC becomes the address of the next instruction plus the sign-extended offset times 4. Otherwise execution falls through to the next instruction.
- R8: Opcode 0x02 takes 3 cycles and sets PC to the top 4 bits of PC followed by the 26-bit field and two zero bits.
- R9: Any other opcode, or opcode 0 with any other function code, returns to step 0 right after decode (2 cycles). It writes no register and no memory.
- R10: Register 0 always reads as zero, even after an instruction targets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 32 | Byte address of the shared memory port |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as mem_addr |
| pc_o | output | 32 | Current program counter |
| step_o | output | 4 | Current step code of the controller |

## Verification
On every cycle, the assertions check the properties of the step sequence alone:
- fetch is followed by decode, with PC advanced by four and the fetch address equal to PC;
- PC holds during decode, and decode leads only to a legal next step;
- writes happen only in the store step, and read and write never overlap;
- the store and load write-back steps return to fetch.

Only the bench's programs can show the values an instruction produces. These cover the arithmetic results, the effective addresses, whether a branch is taken, jump targets, the hard-wired zero register and the absence of side effects from undefined encodings. The bench also shows the cycle count of each instruction class, measured between fetch steps.

// File: rtl/mc_pkg.sv
// Shared types for the multi-cycle processor: step codes, ALU operations,
// operand and PC selects, opcode/function constants and the control bundle.
package mc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDMEM  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STMEM  = 4'd5,
        ST_REXE   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BEQ    = 4'd8,
        ST_JMP    = 4'd9
    } step_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_t;

    typedef enum logic [1:0] {
        BSEL_REG, BSEL_FOUR, BSEL_IMM, BSEL_IMM4
    } bsel_t;

    typedef enum logic [1:0] {
        PCS_ALU, PCS_ALUOUT, PCS_JUMP
    } pcsel_t;

    localparam logic [5:0] OP_REG = 6'h00;
    localparam logic [5:0] OP_LW  = 6'h23;
    localparam logic [5:0] OP_SW  = 6'h2B;
    localparam logic [5:0] OP_BEQ = 6'h04;
    localparam logic [5:0] OP_J   = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic    pc_wr;       // unconditional PC load
        logic    pc_wr_eq;    // PC load when ALU result is zero
        pcsel_t  pc_sel;
        logic    ir_wr;
        logic    mem_rd;
        logic    mem_wr;
        logic    addr_alu;    // memory address from ALU latch, else PC
        logic    ab_wr;
        logic    aluout_wr;
        logic    mdr_wr;
        logic    rf_wr;
        logic    dst_rd;      // destination rd field, else rt
        logic    wb_mdr;      // write-back from memory latch, else ALU latch
        logic    a_reg;       // ALU A from operand latch, else PC
        bsel_t   b_sel;
        alu_op_t alu_op;
    } ctrl_t;

    // Map a register-format function code to an ALU operation.
    function automatic alu_op_t funct_to_op(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    // True for the function codes the block implements.
    function automatic logic funct_ok(input logic [5:0] fn);
        return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
               (fn == FN_OR)  || (fn == FN_SLT);
    endfunction

endpackage

// File: rtl/mc_alu.sv
// Combinational ALU shared by all steps of the multi-cycle datapath.
// Assumes two's-complement operands; SLT compares signed.
module mc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  mc_pkg::alu_op_t op,
    output logic [W-1:0]    y,
    output logic            zero
);
    import mc_pkg::*;

    // Select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
// Register file with two combinational read ports and one synchronous
// write port. Entry 0 is hard-wired to zero; writes to it are dropped.
module mc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] raddr1,
    input  logic [$clog2(NREG)-1:0] raddr2,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [W-1:0]            wdata,
    output logic [W-1:0]            rdata1,
    output logic [W-1:0]            rdata2
);
    logic [W-1:0] regs [NREG];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            if (g == 0) begin : g_zero
                assign regs[g] = '0;
            end else begin : g_store
                logic [W-1:0] q;
                // Capture write data when this entry is addressed.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= '0;
                    else if (we && (waddr == g))
                        q <= wdata;
                end
                assign regs[g] = q;
            end
        end
    endgenerate

    assign rdata1 = regs[raddr1];
    assign rdata2 = regs[raddr2];
endmodule

// File: rtl/mc_ctrl.sv
// Control state machine of the multi-cycle processor. The step register
// advances on every clock; the control bundle is a function of the step
// and, in decode/execute/address steps, of the latched opcode and funct.
// Assumes opcode/funct come from the instruction register.
module mc_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [5:0]          opcode,
    input  logic [5:0]          funct,
    output mc_pkg::ctrl_t       ctrl,
    output mc_pkg::step_t       step
);
    import mc_pkg::*;

    step_t st_q, st_d;

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_FETCH;
        else
            st_q <= st_d;
    end

    // Next-step selection by instruction class.
    always_comb begin
        st_d = ST_FETCH;
        case (st_q)
            ST_FETCH:  st_d = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_LW, OP_SW: st_d = ST_ADDR;
                    OP_REG:       st_d = funct_ok(funct) ? ST_REXE : ST_FETCH;
                    OP_BEQ:       st_d = ST_BEQ;
                    OP_J:         st_d = ST_JMP;
                    default:      st_d = ST_FETCH;
                endcase
            end
            ST_ADDR:   st_d = (opcode == OP_LW) ? ST_LDMEM : ST_STMEM;
            ST_LDMEM:  st_d = ST_LDWB;
            ST_REXE:   st_d = ST_RWB;
            default:   st_d = ST_FETCH;
        endcase
    end

    // Datapath control outputs per step.
    always_comb begin
        ctrl        = '0;
        ctrl.pc_sel = PCS_ALU;
        ctrl.b_sel  = BSEL_REG;
        ctrl.alu_op = ALU_ADD;
        case (st_q)
            ST_FETCH: begin
                ctrl.mem_rd = 1'b1;
                ctrl.ir_wr  = 1'b1;
                ctrl.b_sel  = BSEL_FOUR;
                ctrl.pc_wr  = 1'b1;
            end
            ST_DECODE: begin
                ctrl.ab_wr     = 1'b1;
                ctrl.b_sel     = BSEL_IMM4;
                ctrl.aluout_wr = 1'b1;
            end
            ST_ADDR: begin
                ctrl.a_reg     = 1'b1;
                ctrl.b_sel     = BSEL_IMM;
                ctrl.aluout_wr = 1'b1;
            end
            ST_LDMEM: begin
                ctrl.addr_alu = 1'b1;
                ctrl.mem_rd   = 1'b1;
                ctrl.mdr_wr   = 1'b1;
            end
            ST_LDWB: begin
                ctrl.rf_wr  = 1'b1;
                ctrl.wb_mdr = 1'b1;
            end
            ST_STMEM: begin
                ctrl.addr_alu = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            ST_REXE: begin
                ctrl.a_reg     = 1'b1;
                ctrl.alu_op    = funct_to_op(funct);
                ctrl.aluout_wr = 1'b1;
            end
            ST_RWB: begin
                ctrl.rf_wr  = 1'b1;
                ctrl.dst_rd = 1'b1;
            end
            ST_BEQ: begin
                ctrl.a_reg    = 1'b1;
                ctrl.alu_op   = ALU_SUB;
                ctrl.pc_wr_eq = 1'b1;
                ctrl.pc_sel   = PCS_ALUOUT;
            end
            ST_JMP: begin
                ctrl.pc_wr  = 1'b1;
                ctrl.pc_sel = PCS_JUMP;
            end
            default: ;
        endcase
    end

    assign step = st_q;
endmodule

// File: rtl/mc_cpu.sv
// Multi-cycle processor top: controller plus datapath registers, one
// shared ALU and the register file. One memory port serves instruction
// fetch and data; read data must be valid in the same cycle as the
// address and writes land on the next rising edge.
module mc_cpu #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] pc_o,
    output logic [3:0]      step_o
);
    import mc_pkg::*;

    localparam int RAW = $clog2(NREG);
    localparam int IMM = 16;
    localparam int JFW = 26;

    ctrl_t           c;
    step_t           st;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
    logic [XLEN-1:0] alu_a, alu_b, alu_y, simm, pc_d;
    logic [XLEN-1:0] rf_r1, rf_r2, rf_wd;
    logic [RAW-1:0]  rf_wa;
    logic            alu_zero, pc_en;

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_q[31:26]),
        .funct  (ir_q[5:0]),
        .ctrl   (c),
        .step   (st)
    );

    assign simm = {{(XLEN-IMM){ir_q[IMM-1]}}, ir_q[IMM-1:0]};

    // ALU operand selection.
    always_comb begin
        alu_a = c.a_reg ? a_q : pc_q;
        case (c.b_sel)
            BSEL_FOUR: alu_b = XLEN'(4);
            BSEL_IMM:  alu_b = simm;
            BSEL_IMM4: alu_b = simm << 2;
            default:   alu_b = b_q;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (c.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign rf_wa = c.dst_rd ? ir_q[11 +: RAW] : ir_q[16 +: RAW];
    assign rf_wd = c.wb_mdr ? mdr_q : aluout_q;

    mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr1 (ir_q[21 +: RAW]),
        .raddr2 (ir_q[16 +: RAW]),
        .we     (c.rf_wr),
        .waddr  (rf_wa),
        .wdata  (rf_wd),
        .rdata1 (rf_r1),
        .rdata2 (rf_r2)
    );

    // Next PC selection and conditional update enable.
    always_comb begin
        case (c.pc_sel)
            PCS_ALUOUT: pc_d = aluout_q;
            PCS_JUMP:   pc_d = {pc_q[XLEN-1 -: 4], ir_q[JFW-1:0], 2'b00};
            default:    pc_d = alu_y;
        endcase
        pc_en = c.pc_wr | (c.pc_wr_eq & alu_zero);
    end

    // Datapath state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            ir_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            if (pc_en)       pc_q     <= pc_d;
            if (c.ir_wr)     ir_q     <= mem_rdata;
            if (c.ab_wr)     a_q      <= rf_r1;
            if (c.ab_wr)     b_q      <= rf_r2;
            if (c.aluout_wr) aluout_q <= alu_y;
            if (c.mdr_wr)    mdr_q    <= mem_rdata;
        end
    end

    assign mem_addr  = c.addr_alu ? aluout_q : pc_q;
    assign mem_rd    = c.mem_rd;
    assign mem_wr    = c.mem_wr;
    assign mem_wdata = b_q;
    assign pc_o      = pc_q;
    assign step_o    = st;
endmodule

// File: rtl/mc_cpu_chk.sv
// Checker for mc_cpu: step-sequence and memory-strobe properties on the
// top-level ports. Attached to every mc_cpu instance by the bind below.
module mc_cpu_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [XLEN-1:0] pc_o,
    input logic [3:0]      step_o
);
    p_no_rdwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd0) |=> (step_o == 4'd1));

    p_fetch_pcinc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd0) |=> (pc_o == $past(pc_o) + XLEN'(4)));

    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd0) |-> (mem_rd && mem_addr == pc_o));

    p_decode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd1) |=> $stable(pc_o));

    p_decode_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd1) |=> (step_o inside {4'd0, 4'd2, 4'd6, 4'd8, 4'd9}));

    p_write_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (step_o == 4'd5));

    p_store_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd5) |=> (step_o == 4'd0));

    p_load_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 4'd4) |=> (step_o == 4'd0));
endmodule

bind mc_cpu mc_cpu_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .pc_o     (pc_o),
    .step_o   (step_o)
);

// File: tb/mc_cpu_tb.sv
`timescale 1ns/1ps
// Bench: runs short programs from a bench-side memory and checks results,
// per-instruction cycle counts and write activity against computed values.
module mc_cpu_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_o;
    logic        mem_rd, mem_wr;
    logic [3:0]  step_o;

    logic [31:0] mem [0:63];
    logic [31:0] img [0:63];
    logic        ld_en = 0;
    logic [5:0]  ld_idx = 0;
    logic [31:0] ld_data = 0;

    int n_chk = 0, n_fail = 0;
    int fetch_at [0:15];
    int nf, nwr;
    logic [31:0] pc_at [0:63];

    always #10 clk = ~clk;   // 50 MHz

    mc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .step_o(step_o)
    );

    assign mem_rdata = mem[mem_addr[7:2]];

    // Memory model: bench load port and DUT write port.
    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_data;
        else if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, rt, rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {6'h02, idx};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 64; i++) img[i] = 32'h0;
    endtask

    // Load image under reset, release, then run and record fetch cycles.
    task automatic run(input int ncyc, input bit chk_reset);
        rst_n = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            ld_en = 1; ld_idx = 6'(i); ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 0;
        @(negedge clk);
        if (chk_reset) begin
            check("R1 reset pc", pc_o, 32'h0);
            check("R1 reset step", {28'h0, step_o}, 32'h0);
            check("R1 reset wr", {31'h0, mem_wr}, 32'h0);
        end
        rst_n = 1;
        nf = 0; nwr = 0;
        for (int k = 0; k < ncyc; k++) begin
            if (step_o == 4'd0 && nf < 16) begin
                fetch_at[nf] = k;
                nf++;
            end
            if (mem_wr) nwr++;
            pc_at[k] = pc_o;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] ref_op(input int op, input logic [31:0] a, b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return {31'h0, $signed(a) < $signed(b)};
        endcase
    endfunction

    logic [31:0] vals [0:5];
    logic [5:0]  fns [0:4];

    initial begin
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7;        vals[4] = 32'h8000_0000; vals[5] = 32'h7FFF_FFFF;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;

        // R4/R5/R6/R8: every operation over every operand pair.
        for (int op = 0; op < 5; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    clear_img();
                    img[0] = enc_i(6'h23, 0, 1, 16'd128);
                    img[1] = enc_i(6'h23, 0, 2, 16'd132);
                    img[2] = enc_r(fns[op], 1, 2, 3);
                    img[3] = enc_i(6'h2B, 0, 3, 16'd136);
                    img[4] = enc_j(26'd4);
                    img[32] = vals[i]; img[33] = vals[j]; img[34] = 32'hDEAD_BEEF;
                    run(26, (op == 0 && i == 0 && j == 0));
                    check("R4 result", mem[34], ref_op(op, vals[i], vals[j]));
                    check("R5 lw cycles", 32'(fetch_at[1] - fetch_at[0]), 32'd5);
                    check("R4 reg op cycles", 32'(fetch_at[3] - fetch_at[2]), 32'd4);
                    check("R6 sw cycles", 32'(fetch_at[4] - fetch_at[3]), 32'd4);
                    check("R8 j cycles", 32'(fetch_at[5] - fetch_at[4]), 32'd3);
                    check("R6 write count", 32'(nwr), 32'd1);
                    check("R8 j target", pc_at[fetch_at[5]], 32'd16);
                end
            end
        end

        // R7: branch taken exactly when operands are equal.
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                clear_img();
                img[0] = enc_i(6'h23, 0, 1, 16'd128);
                img[1] = enc_i(6'h23, 0, 2, 16'd132);
                img[2] = enc_i(6'h04, 1, 2, 16'd1);
                img[3] = enc_i(6'h2B, 0, 1, 16'd136);
                img[4] = enc_i(6'h2B, 0, 2, 16'd140);
                img[5] = enc_j(26'd5);
                img[32] = vals[i]; img[33] = vals[j];
                img[34] = 32'hDEAD_BEEF; img[35] = 32'h5555_5555;
                run(32, 1'b0);
                check("R7 fallthrough store",
                      mem[34], (i == j) ? 32'hDEAD_BEEF : vals[i]);
                check("R7 target store", mem[35], vals[j]);
                check("R7 beq cycles", 32'(fetch_at[3] - fetch_at[2]), 32'd3);
                check("R7 next pc", pc_at[fetch_at[3]], (i == j) ? 32'd16 : 32'd12);
            end
        end

        // R8/R10: forward jump skips a store; register 0 stays zero.
        clear_img();
        img[0] = enc_j(26'd8);
        img[1] = enc_i(6'h2B, 0, 0, 16'd140);
        img[8] = enc_i(6'h23, 0, 0, 16'd128);
        img[9] = enc_i(6'h2B, 0, 0, 16'd136);
        img[10] = enc_j(26'd10);
        img[32] = 32'h1234_5678; img[34] = 32'hDEAD_BEEF; img[35] = 32'h5555_5555;
        run(24, 1'b0);
        check("R8 jump pc", pc_at[fetch_at[1]], 32'd32);
        check("R8 skipped store", mem[35], 32'h5555_5555);
        check("R10 r0 reads zero", mem[34], 32'h0);

        // R9: undefined opcode and undefined function code have no effect.
        clear_img();
        img[0] = enc_i(6'h3F, 0, 5, 16'd128);
        img[1] = enc_r(6'h3F, 0, 0, 5);
        img[2] = enc_i(6'h2B, 0, 5, 16'd136);
        img[3] = enc_j(26'd3);
        img[32] = 32'h1111_1111; img[34] = 32'hDEAD_BEEF;
        run(16, 1'b0);
        check("R9 bad opcode cycles", 32'(fetch_at[1] - fetch_at[0]), 32'd2);
        check("R9 bad funct cycles", 32'(fetch_at[2] - fetch_at[1]), 32'd2);
        check("R9 no reg write", mem[34], 32'h0);
        check("R9 no mem write", 32'(nwr), 32'd1);
        check("R9 data intact", mem[32], 32'h1111_1111);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule